// File: doc/BRIEF.md
# Delay-Line Lock Search and Qualifier

This block is the digital side of a master delay line. After a restart it loads a programmable start code and sweeps the delay code by a programmable step until the phase detector reports a lock indication. It then declares lock only when the recent samples contain a long enough unbroken run of indications. Scattered single hits do not count. While locked it holds the code. When the qualifying run ages out of the window, it drops lock and resumes the sweep from the code where lock was lost.

For debug, a 32-bit status word reports four items: the code at which lock was most recently lost, the seven newest detector samples, the code at which lock was declared, and the lock flag. When lock is declared, the locked code is copied to a set of slave delay outputs, one per data slice. The spacing of the analogue lock detectors is passed through to the delay line with a range limit. The analogue elements themselves sit outside this block.

Top module: `delay_lock_ctrl`

## Requirements
- R1: After reset every output is zero, and the controller stays idle (`dly_code` does not move and `locked` stays low, whatever `pd_hit` does) until the first `restart`.
- R2: A `restart` loads `dly_code` with `cfg_start`, raised to 4 if smaller, sets the sweep direction to upward, and clears the sample history, the lock flag and the lock code. The lost-lock code is kept.
- R3: While running and unlocked, each cycle with `pd_hit` low moves `dly_code` by `cfg_step` in the current direction. A cycle with `pd_hit` high holds the code.
- R4: A step that would pass 255 stops at 255, and a step that would pass 0 stops at 0; either case reverses the sweep direction.
- R5: Lock is declared at the clock edge that samples the hit completing a run of N consecutive hits among the last 8 samples. N is `cfg_need`, with 0 treated as 1 and values above 8 treated as 8. The history 11110000 qualifies for N=4; the history 10101010 does not.
- R6: On lock, the current `dly_code` is recorded as the lock code.
- R7: While locked the code is held. When no qualifying run remains in the window, the lock flag clears and the held code is recorded as the lost-lock code. Sweeping resumes from that code on the following cycle.
- R8: The `status_word` layout is: bits 31:24 lost-lock code (zero until lock is first lost); bits 23:17 the seven newest samples, with the newest in bit 17; bits 15:8 the lock code; bit 0 the lock flag. The other bits are zero.
- R9: Each slave code field `slave_codes[8*i+7:8*i]` takes `dly_code` when lock is declared and holds that value at all other times.
- R10: `det_spacing` equals `cfg_spacing` limited to a maximum of 4. An encoding of k selects k+1 delay elements between the lock detectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart of the search |
| cfg_start | input | 8 | Start delay code (minimum effective value 4) |
| cfg_step | input | 8 | Sweep step size |
| cfg_need | input | 4 | Required run length of consecutive lock indications |
| cfg_spacing | input | 3 | Detector spacing request |
| pd_hit | input | 1 | Phase-detector lock indication for this cycle |
| det_spacing | output | 3 | Detector spacing sent to the delay line (limited to 4) |
| dly_code | output | 8 | Master delay code |
| locked | output | 1 | Lock flag |
| status_word | output | 32 | Debug status word (layout in R8) |
| slave_codes | output | 24 | Three 8-bit slave delay codes |

## Verification
A fault in the run qualifier shows up as `locked` rising or falling one or more cycles away from the sample that completes or breaks the run. The bench catches this at the sample itself, using the 11110000 and 10101010 patterns. A wrong sweep state appears on `dly_code` within one cycle of the step. The saturation cases are checked at the exact edges where the code reaches 255 and 0. Faults in capture or in the restart path remain visible in `status_word` and `slave_codes` until the next lock event, so they are compared after the loss and after the restart.

// File: rtl/dlc_pkg.sv
`timescale 1ns/1ps
package dlc_pkg;
  localparam int CODE_W    = 8;
  localparam int WIN       = 8;
  localparam int NEED_W    = 4;
  localparam int SPC_W     = 3;
  localparam int MIN_START = 4;
  localparam int MAX_SPC   = 4;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [WIN-1:0]    win_t;
  typedef logic [NEED_W-1:0] need_t;

  typedef struct packed {
    logic  up;
    code_t code;
  } step_res_t;

  // longest unbroken run of ones anywhere in the window
  function automatic need_t longest_run(win_t w);
    need_t best;
    need_t cur;
    best = '0;
    cur  = '0;
    for (int i = 0; i < WIN; i++) begin
      if (w[i]) begin
        cur = cur + NEED_W'(1);
        if (cur > best) best = cur;
      end else begin
        cur = '0;
      end
    end
    return best;
  endfunction

  function automatic need_t eff_need(need_t n);
    if (n == '0) return NEED_W'(1);
    if (int'(n) > WIN) return NEED_W'(WIN);
    return n;
  endfunction

  function automatic code_t clamp_start(code_t s);
    if (int'(s) < MIN_START) return CODE_W'(MIN_START);
    return s;
  endfunction

  function automatic logic [SPC_W-1:0] clamp_spacing(logic [SPC_W-1:0] s);
    if (int'(s) > MAX_SPC) return SPC_W'(MAX_SPC);
    return s;
  endfunction

  // one sweep step with saturation and direction reversal at the rails
  function automatic step_res_t step_code(code_t c, code_t s, logic up);
    step_res_t r;
    logic [CODE_W:0] sum;
    sum = '0;
    if (up) begin
      sum = {1'b0, c} + {1'b0, s};
      if (sum[CODE_W]) begin
        r.code = '1;
        r.up   = 1'b0;
      end else begin
        r.code = sum[CODE_W-1:0];
        r.up   = 1'b1;
      end
    end else begin
      if (s > c) begin
        r.code = '0;
        r.up   = 1'b1;
      end else begin
        r.code = c - s;
        r.up   = 1'b0;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/dlc_run_qualifier.sv
`timescale 1ns/1ps
module dlc_run_qualifier
  import dlc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  sample_en,
  input  logic  sample,
  input  need_t need_eff,
  output win_t  hist,
  output logic  qual_now
);
  win_t hist_next;

  assign hist_next = sample_en ? {hist[WIN-2:0], sample} : hist;
  assign qual_now  = (longest_run(hist_next) >= need_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hist <= '0;
    else if (clear)     hist <= '0;
    else if (sample_en) hist <= hist_next;
  end

  // newest sample lands in bit 0 (R8 history field)
  assert_hist_newest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !clear) |=> (hist[0] == $past(sample)));
endmodule

// File: rtl/dlc_code_stepper.sv
`timescale 1ns/1ps
module dlc_code_stepper
  import dlc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  code_t load_val,
  input  logic  step_en,
  input  code_t step,
  output code_t code,
  output logic  dir_up
);
  step_res_t nxt;

  assign nxt = step_code(code, step, dir_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= '0;
      dir_up <= 1'b1;
    end else if (load) begin
      code   <= load_val;
      dir_up <= 1'b1;
    end else if (step_en) begin
      code   <= nxt.code;
      dir_up <= nxt.up;
    end
  end

  assert_top_rail_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && dir_up && (code == '1) && (step != '0)) |=> (!dir_up && code == $past(code) - $past(step)) or (!dir_up));
  assert_bottom_rail_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && !dir_up && (step > code)) |=> (dir_up && code == '0));
endmodule

// File: rtl/dlc_slave_fanout.sv
`timescale 1ns/1ps
module dlc_slave_fanout
  import dlc_pkg::*;
#(
  parameter int NUM_SLAVES = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           capture,
  input  code_t                          code_in,
  output logic [NUM_SLAVES*CODE_W-1:0]   slave_codes
);
  for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_slot
    code_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (capture) q <= code_in;
    end
    assign slave_codes[g*CODE_W +: CODE_W] = q;
  end
endmodule

// File: rtl/delay_lock_ctrl.sv
`timescale 1ns/1ps
module delay_lock_ctrl
  import dlc_pkg::*;
#(
  parameter int NUM_SLAVES = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         restart,
  input  logic [CODE_W-1:0]            cfg_start,
  input  logic [CODE_W-1:0]            cfg_step,
  input  logic [NEED_W-1:0]            cfg_need,
  input  logic [SPC_W-1:0]             cfg_spacing,
  input  logic                         pd_hit,
  output logic [SPC_W-1:0]             det_spacing,
  output logic [CODE_W-1:0]            dly_code,
  output logic                         locked,
  output logic [31:0]                  status_word,
  output logic [NUM_SLAVES*CODE_W-1:0] slave_codes
);
  logic  running;
  code_t lock_code;
  code_t lost_code;
  win_t  hist;
  logic  qual_now;
  logic  dir_up;
  need_t need_eff;

  // named internal events
  logic  active;
  logic  lock_declare;
  logic  lock_drop;
  logic  sweep_en;

  assign need_eff     = eff_need(cfg_need);
  assign active       = running && !restart;
  assign lock_declare = active && !locked && qual_now;
  assign lock_drop    = active && locked && !qual_now;
  assign sweep_en     = active && !locked && !qual_now && !pd_hit;
  assign det_spacing  = clamp_spacing(cfg_spacing);

  dlc_run_qualifier u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (restart),
    .sample_en (active),
    .sample    (pd_hit),
    .need_eff  (need_eff),
    .hist      (hist),
    .qual_now  (qual_now)
  );

  dlc_code_stepper u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (restart),
    .load_val (clamp_start(cfg_start)),
    .step_en  (sweep_en),
    .step     (cfg_step),
    .code     (dly_code),
    .dir_up   (dir_up)
  );

  dlc_slave_fanout #(.NUM_SLAVES(NUM_SLAVES)) u_fan (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (lock_declare),
    .code_in     (dly_code),
    .slave_codes (slave_codes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      locked    <= 1'b0;
      lock_code <= '0;
      lost_code <= '0;
    end else if (restart) begin
      running   <= 1'b1;
      locked    <= 1'b0;
      lock_code <= '0;
    end else if (lock_declare) begin
      locked    <= 1'b1;
      lock_code <= dly_code;
    end else if (lock_drop) begin
      locked    <= 1'b0;
      lost_code <= dly_code;
    end
  end

  assign status_word = {lost_code, hist[6:0], 1'b0, lock_code, 7'b0, locked};

  assert_idle_still_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart) |=> ($stable(dly_code) && !locked));
  assert_restart_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (dly_code >= CODE_W'(MIN_START) && !locked && hist == '0));
  assert_hit_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !restart && !locked && pd_hit) |=> $stable(dly_code));
  assert_lock_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> hist[0]);
  assert_lock_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (lock_code == dly_code));
  assert_hold_while_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (!locked || $stable(dly_code)));
  assert_lost_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && !$past(restart)) |-> (lost_code == dly_code));
  assert_slave_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (slave_codes[CODE_W-1:0] == dly_code));
  assert_spacing_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    det_spacing <= SPC_W'(MAX_SPC));
endmodule

// File: tb/delay_lock_ctrl_bench.sv
`timescale 1ns/1ps
module delay_lock_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        pd_hit = 1'b0;
  logic [7:0]  cfg_start = '0;
  logic [7:0]  cfg_step = '0;
  logic [3:0]  cfg_need = '0;
  logic [2:0]  cfg_spacing = '0;
  logic [2:0]  det_spacing;
  logic [7:0]  dly_code;
  logic        locked;
  logic [31:0] status_word;
  logic [23:0] slave_codes;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   auto_mode = 1'b0;
  bit   done = 1'b0;
  logic [7:0] win_lo = '0;
  logic [7:0] win_hi = '0;

  always #2.5 clk = ~clk;

  delay_lock_ctrl u_delay_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .cfg_start(cfg_start), .cfg_step(cfg_step), .cfg_need(cfg_need),
    .cfg_spacing(cfg_spacing), .pd_hit(pd_hit),
    .det_spacing(det_spacing), .dly_code(dly_code), .locked(locked),
    .status_word(status_word), .slave_codes(slave_codes)
  );

  // {start, step, need, window low, window high, expected lock code}
  localparam logic [47:0] VEC [5] = '{
    48'h20_04_04_30_40_30,
    48'hF0_10_03_08_20_1F,
    48'h40_02_00_45_50_46,
    48'h10_01_0C_10_80_10,
    48'h01_01_02_04_10_04
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      if (auto_mode) pd_hit = (dly_code >= win_lo) && (dly_code <= win_hi);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic drive(logic b);
    pd_hit = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset code", dly_code, 0);
    chk("R1 reset status", status_word, 0);
    chk("R1 reset slaves", slave_codes, 0);
    cfg_start = 8'h30; cfg_step = 8'h05; cfg_need = 4'd0;
    pd_hit = 1'b1;
    cyc(5);
    pd_hit = 1'b0;
    cyc(3);
    chk("R1 idle code", dly_code, 0);
    chk("R1 idle lock", locked, 0);

    for (int v = 0; v < 5; v++) begin
      cfg_start = VEC[v][47:40];
      cfg_step  = VEC[v][39:32];
      cfg_need  = VEC[v][27:24];
      win_lo    = VEC[v][23:16];
      win_hi    = VEC[v][15:8];
      auto_mode = 1'b1;
      do_restart();
      cyc(64);
      chk("R3/R4 final code", dly_code, VEC[v][7:0]);
      chk("R5 locked", locked, 1);
      chk("R6 lock code", status_word[15:8], VEC[v][7:0]);
      for (int s = 0; s < 3; s++)
        chk("R9 slave", slave_codes[8*s +: 8], VEC[v][7:0]);
      if (v == 0) begin
        chk("R8 lost code zero", status_word[31:24], 0);
        chk("R8 lock bit", status_word[0], 1);
      end
    end
    auto_mode = 1'b0;

    // scattered versus consecutive hits, N=4, step 0
    cfg_start = 8'h50; cfg_step = 8'h00; cfg_need = 4'd4;
    do_restart();
    for (int i = 0; i < 8; i++) drive(~i[0]);
    chk("R5 alternating no lock", locked, 0);
    drive(1'b1); drive(1'b1); drive(1'b1);
    chk("R5 run of 3 no lock", locked, 0);
    drive(1'b1);
    chk("R5 run of 4 locks", locked, 1);
    chk("R6 lock code", status_word[15:8], 8'h50);
    chk("R8 history", status_word[23:17], 7'h2F);

    // loss of lock
    cfg_step = 8'h03;
    for (int i = 0; i < 4; i++) drive(1'b0);
    chk("R5 11110000 still locked", locked, 1);
    chk("R7 held code", dly_code, 8'h50);
    drive(1'b0);
    chk("R7 lock dropped", locked, 0);
    chk("R7 lost code", status_word[31:24], 8'h50);
    chk("R7 code at drop", dly_code, 8'h50);
    drive(1'b0);
    chk("R7 resume sweep", dly_code, 8'h53);
    chk("R9 slave holds", slave_codes, 24'h505050);

    // restart keeps lost code, clamps start
    cfg_start = 8'h02;
    do_restart();
    chk("R2 start clamp", dly_code, 8'h04);
    chk("R2 lock cleared", locked, 0);
    chk("R2 history cleared", status_word[23:17], 0);
    chk("R2 lost kept", status_word[31:24], 8'h50);
    chk("R2 lock code cleared", status_word[15:8], 0);

    // saturation at both rails
    cfg_need = 4'd8; cfg_start = 8'hFA; cfg_step = 8'h08;
    pd_hit = 1'b0;
    do_restart();
    chk("R2 start load", dly_code, 8'hFA);
    drive(1'b0);
    chk("R4 top rail", dly_code, 8'hFF);
    drive(1'b0);
    chk("R4 reversed", dly_code, 8'hF7);
    for (int i = 0; i < 30; i++) drive(1'b0);
    chk("R3 downward sweep", dly_code, 8'h07);
    drive(1'b0);
    chk("R4 bottom rail", dly_code, 8'h00);
    drive(1'b0);
    chk("R4 reversed up", dly_code, 8'h08);

    // spacing limit
    cfg_spacing = 3'd7;
    #1;
    chk("R10 spacing cap", det_spacing, 3'd4);
    cfg_spacing = 3'd3;
    #1;
    chk("R10 spacing pass", det_spacing, 3'd3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule